// File: doc/BRIEF.md
# Queued Lock Handoff Manager

This block arbitrates one shared lock among a set of requesters by keeping an explicit waiting line in hardware. Every holder or waiter owns a node register with a wait flag, a successor pointer and a flag that marks the pointer valid. A tail register names the last node in the line. An accepted acquire exchanges the tail for its own node. The previous tail becomes its predecessor, and in the next cycle the predecessor's successor pointer is written. Each requester's grant depends only on its own node: the grant is high when the node is in the line and its wait flag is clear.

A release hands the lock straight to the linked successor by clearing that successor's wait flag. If the releasing node is still the tail, the release instead empties the tail, acting as a compare-and-swap. If a successor has already taken the tail but its link has not been written yet, the release is held until the link is valid. Acquire and release are one-cycle strobes. Each strobe carries a node index, and that index is chosen independently of the requester number.

Top module: `qlock_mgr`

## Requirements
- R1: Out of reset, every grant is low and the line is empty.
- R2: An acquire accepted while the line is empty raises that requester's grant in the cycle after the strobe is sampled.
- R3: At most one grant is high at any time. A requester that joins a non-empty line keeps its grant low until the lock is handed to it.
- R4: Acquire strobes sampled in the same cycle are accepted one per cycle, lowest requester number first. The strobes that lose are held internally until they are accepted.
- R5: Grants are given in exactly the order in which acquires take the tail (first in, first out).
- R6: A release by the holder whose successor link is already valid drops the holder's grant and raises the successor's grant at the same clock edge.
- R7: A release by the holder while its node is the tail, with no acquire in that cycle, leaves every grant low. A later acquire, which may reuse the freed node index, is then granted under R2.
- R8: If a release finds no valid successor link, it waits with every grant low. The successor is granted at the first edge that sees the link valid. For a release in the same cycle as the successor's tail swap, that is two edges after the release. For a release one cycle after the swap, it is one edge after the release.
- R9: A release strobe is ignored unless the requester currently holds the lock and names the node it acquired with. Grants are unchanged after an ignored release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_stb | input | NREQ | One-cycle acquire strobe per requester |
| acq_node | input | NREQ*NW | Node index per requester for its acquire (field r at bits r*NW upward) |
| rel_stb | input | NREQ | One-cycle release strobe per requester |
| rel_node | input | NREQ*NW | Node index per requester for its release (same field layout) |
| grant | output | NREQ | Lock-held indication per requester |

## Verification
The assertions assume three things about the inputs. First, a requester has at most one acquire outstanding: it does not strobe again while it is waiting for acceptance, queued, or holding the lock. Second, the nodes in the line have distinct indices. Third, a node index is not presented again until the release of that node has resolved, either by emptying the tail or by waking a successor. The stimulus respects all three by design: each requester acquires only after its previous release has completed, each queued requester gets its own index, and an index is reused only after its holder's release has completed. Within those limits, the stimulus deliberately targets the two link-window cases and a same-cycle burst of acquires.

// File: rtl/qlock_pkg.sv
package qlock_pkg;

  // Position of the least significant set bit, zero when none is set.
  function automatic int unsigned lowest_set(input logic [63:0] v);
    for (int i = 0; i < 64; i++) begin
      if (v[i]) return i;
    end
    return 0;
  endfunction

  // A node is the head (lock holder) when it is queued and not waiting.
  function automatic logic is_head(input logic active, input logic waiting);
    return active && !waiting;
  endfunction

endpackage

// File: rtl/qlock_arb.sv
module qlock_arb
  import qlock_pkg::*;
#(
  parameter int NREQ = 8,
  parameter int NW   = 3,
  localparam int RW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREQ-1:0]      acq_stb,
  input  logic [NREQ*NW-1:0]   acq_node,
  output logic                 fire,
  output logic [RW-1:0]        win_req,
  output logic [NW-1:0]        win_node
);

  logic [NREQ-1:0] held_q;
  logic [NW-1:0]   held_node_q [NREQ];
  logic [NREQ-1:0] cand;
  logic [NW-1:0]   cand_node [NREQ];

  for (genvar r = 0; r < NREQ; r++) begin : g_cand
    assign cand_node[r] = acq_stb[r] ? acq_node[r*NW +: NW] : held_node_q[r];
  end

  always_comb begin
    cand     = held_q | acq_stb;
    fire     = |cand;
    win_req  = RW'(lowest_set(64'(cand)));
    win_node = cand_node[win_req];
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held_q[r]      <= 1'b0;
        held_node_q[r] <= '0;
      end else begin
        held_q[r]      <= cand[r] && (win_req != RW'(r));
        held_node_q[r] <= cand_node[r];
      end
    end
  end

endmodule

// File: rtl/qlock_nodes.sv
module qlock_nodes
  import qlock_pkg::*;
#(
  parameter int NREQ  = 8,
  parameter int NNODE = 8,
  localparam int NW   = (NNODE > 1) ? $clog2(NNODE) : 1,
  localparam int RW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_en,
  input  logic [NW-1:0]         init_idx,
  input  logic                  init_wait,
  input  logic [RW-1:0]         init_owner,
  input  logic                  link_en,
  input  logic [NW-1:0]         link_pred,
  input  logic [NW-1:0]         link_succ,
  input  logic                  kill_en,
  input  logic [NW-1:0]         kill_idx,
  input  logic                  wake_en,
  input  logic [NW-1:0]         wake_idx,
  output logic [NNODE-1:0]      active,
  output logic [NNODE-1:0]      waiting,
  output logic [NNODE-1:0]      nxt_ok,
  output logic [NNODE*NW-1:0]   nxt_flat,
  output logic [NNODE*RW-1:0]   own_flat,
  output logic [NREQ-1:0]       grant
);

  for (genvar k = 0; k < NNODE; k++) begin : g_node
    logic [NW-1:0] nxt_q;
    logic [RW-1:0] own_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        active[k]  <= 1'b0;
        waiting[k] <= 1'b0;
        nxt_ok[k]  <= 1'b0;
        nxt_q      <= '0;
        own_q      <= '0;
      end else begin
        if (init_en && init_idx == NW'(k)) begin
          active[k]  <= 1'b1;
          waiting[k] <= init_wait;
          nxt_ok[k]  <= 1'b0;
          own_q      <= init_owner;
        end
        if (link_en && link_pred == NW'(k)) begin
          nxt_ok[k] <= 1'b1;
          nxt_q     <= link_succ;
        end
        if (kill_en && kill_idx == NW'(k)) active[k] <= 1'b0;
        if (wake_en && wake_idx == NW'(k)) waiting[k] <= 1'b0;
      end
    end

    assign nxt_flat[k*NW +: NW] = nxt_q;
    assign own_flat[k*RW +: RW] = own_q;
  end

  // Each requester watches only the node it owns.
  always_comb begin
    grant = '0;
    for (int k = 0; k < NNODE; k++) begin
      if (is_head(active[k], waiting[k])) grant[own_flat[k*RW +: RW]] = 1'b1;
    end
  end

endmodule

// File: rtl/qlock_mgr.sv
module qlock_mgr
  import qlock_pkg::*;
#(
  parameter int NREQ  = 8,
  parameter int NNODE = 8,
  localparam int NW   = (NNODE > 1) ? $clog2(NNODE) : 1,
  localparam int RW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREQ-1:0]     acq_stb,
  input  logic [NREQ*NW-1:0]  acq_node,
  input  logic [NREQ-1:0]     rel_stb,
  input  logic [NREQ*NW-1:0]  rel_node,
  output logic [NREQ-1:0]     grant
);

  // Named events for the checker.
  logic          swap, acc_empty, rel_hit, rel_free, rel_direct, rel_wait;
  logic          pend_go, handoff;
  logic [RW-1:0] win_req;
  logic [NW-1:0] win_node, rel_idx, succ_idx;

  logic          tail_vld, link_vld, rp_vld;
  logic [NW-1:0] tail_idx, link_pred, link_succ, rp_idx;

  logic [NNODE-1:0]    active, waiting, nxt_ok;
  logic [NNODE*NW-1:0] nxt_flat;
  logic [NNODE*RW-1:0] own_flat;
  logic [NW-1:0]       rel_n [NREQ];

  qlock_arb #(.NREQ(NREQ), .NW(NW)) u_arb (
    .clk(clk), .rst_n(rst_n), .acq_stb(acq_stb), .acq_node(acq_node),
    .fire(swap), .win_req(win_req), .win_node(win_node)
  );

  for (genvar r = 0; r < NREQ; r++) begin : g_reln
    assign rel_n[r] = rel_node[r*NW +: NW];
  end

  // A release counts only from the holder naming its own node.
  always_comb begin
    rel_hit = 1'b0;
    rel_idx = '0;
    for (int r = 0; r < NREQ; r++) begin
      if (rel_stb[r] && is_head(active[rel_n[r]], waiting[rel_n[r]]) &&
          own_flat[rel_n[r]*RW +: RW] == RW'(r)) begin
        rel_hit = 1'b1;
        rel_idx = rel_n[r];
      end
    end
  end

  always_comb begin
    acc_empty  = swap && !tail_vld;
    rel_free   = rel_hit && !swap && tail_vld && (tail_idx == rel_idx);
    rel_direct = rel_hit && !rel_free && nxt_ok[rel_idx];
    rel_wait   = rel_hit && !rel_free && !nxt_ok[rel_idx];
    pend_go    = rp_vld && nxt_ok[rp_idx];
    handoff    = rel_direct || pend_go;
    succ_idx   = rel_direct ? nxt_flat[rel_idx*NW +: NW] : nxt_flat[rp_idx*NW +: NW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_vld  <= 1'b0;
      tail_idx  <= '0;
      link_vld  <= 1'b0;
      link_pred <= '0;
      link_succ <= '0;
      rp_vld    <= 1'b0;
      rp_idx    <= '0;
    end else begin
      // Tail exchange wins over the release compare-and-swap.
      if (swap) begin
        tail_vld <= 1'b1;
        tail_idx <= win_node;
      end else if (rel_free) begin
        tail_vld <= 1'b0;
      end
      link_vld  <= swap && tail_vld;
      link_pred <= tail_idx;
      link_succ <= win_node;
      if (rel_wait) begin
        rp_vld <= 1'b1;
        rp_idx <= rel_idx;
      end else if (pend_go) begin
        rp_vld <= 1'b0;
      end
    end
  end

  qlock_nodes #(.NREQ(NREQ), .NNODE(NNODE)) u_nodes (
    .clk(clk), .rst_n(rst_n),
    .init_en(swap), .init_idx(win_node), .init_wait(tail_vld), .init_owner(win_req),
    .link_en(link_vld), .link_pred(link_pred), .link_succ(link_succ),
    .kill_en(rel_hit), .kill_idx(rel_idx),
    .wake_en(handoff), .wake_idx(succ_idx),
    .active(active), .waiting(waiting), .nxt_ok(nxt_ok),
    .nxt_flat(nxt_flat), .own_flat(own_flat), .grant(grant)
  );

endmodule

// File: rtl/qlock_mgr_chk.sv
module qlock_mgr_chk #(
  parameter int NREQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] grant,
  input logic            acc_empty,
  input logic            handoff,
  input logic            rel_free,
  input logic            rp_vld
);

  // R3: mutual exclusion
  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2: empty-line acquire is granted one cycle later
  a_r2_empty_grant: assert property (@(posedge clk) disable iff (!rst_n)
    acc_empty |=> (grant != '0));

  // R6: a handoff leaves exactly one holder
  a_r6_handoff_one: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |=> $onehot(grant));

  // R7: freeing the tail leaves the lock idle
  a_r7_free_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rel_free |=> (grant == '0));

  // R8: nobody holds the lock while a release waits for its link
  a_r8_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rp_vld |-> (grant == '0));

  // R5: a new owner appears only through empty-line acceptance or handoff
  a_r5_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && !$stable(grant)) |-> $past(acc_empty || handoff));

endmodule

bind qlock_mgr qlock_mgr_chk #(.NREQ(NREQ)) u_qlock_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .acc_empty(acc_empty),
  .handoff(handoff), .rel_free(rel_free), .rp_vld(rp_vld)
);

// File: tb/qlock_mgr_bench.sv
module qlock_mgr_bench;
  localparam int NREQ  = 8;
  localparam int NNODE = 8;
  localparam int NW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0]    acq_stb = '0, rel_stb = '0;
  logic [NREQ*NW-1:0] acq_node = '0, rel_node = '0;
  logic [NREQ-1:0]    grant;

  always #5 clk = ~clk;

  qlock_mgr #(.NREQ(NREQ), .NNODE(NNODE)) u_qlock_mgr (
    .clk(clk), .rst_n(rst_n), .acq_stb(acq_stb), .acq_node(acq_node),
    .rel_stb(rel_stb), .rel_node(rel_node), .grant(grant)
  );

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  bit done = 1'b0;
  logic [NREQ-1:0] last_g = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NREQ*NW-1:0] put(input int r, input int n);
    logic [NREQ*NW-1:0] v = '0;
    v[r*NW +: NW] = NW'(n);
    return v;
  endfunction

  function automatic int bit_of(input int r);
    return 1 << r;
  endfunction

  // Called at a falling edge: drive, let one rising edge sample, clear.
  task automatic step(input logic [NREQ-1:0] am, input logic [NREQ*NW-1:0] an,
                      input logic [NREQ-1:0] rm, input logic [NREQ*NW-1:0] rn);
    acq_stb = am; acq_node = an; rel_stb = rm; rel_node = rn;
    @(negedge clk);
    acq_stb = '0; acq_node = '0; rel_stb = '0; rel_node = '0;
  endtask

  // Driver: expected grant order pushed at acquire time.
  task automatic acq(input int r, input int n);
    exp_q.push_back(r);
    step(NREQ'(bit_of(r)), put(r, n), '0, '0);
  endtask

  task automatic rel(input int r, input int n);
    step('0, '0, NREQ'(bit_of(r)), put(r, n));
  endtask

  // Monitor: every new owner must be the next one in the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (grant != last_g && grant != '0) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected grant", int'(grant), 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(grant == NREQ'(bit_of(e)), "R5 fifo order", int'(grant), bit_of(e));
        end
      end
      last_g = grant;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R5 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(grant == '0, "R1 reset idle", int'(grant), 0);

    // Empty-line acquire
    acq(2, 5);
    chk(grant == 8'h04, "R2 empty grant", int'(grant), 4);

    // Releases by a non-holder, and by the holder with a wrong node
    rel(3, 5);
    chk(grant == 8'h04, "R9 non-holder release", int'(grant), 4);
    rel(2, 0);
    chk(grant == 8'h04, "R9 wrong node release", int'(grant), 4);

    // Two waiters queue behind the holder
    acq(4, 1);
    chk(grant == 8'h04, "R3 waiter held", int'(grant), 4);
    step('0, '0, '0, '0);
    acq(1, 7);
    step('0, '0, '0, '0);
    step('0, '0, '0, '0);
    chk(grant == 8'h04, "R3 two waiters held", int'(grant), 4);
    rel(2, 5);
    chk(grant == 8'h10, "R6 handoff to r4", int'(grant), 16);
    rel(4, 1);
    chk(grant == 8'h02, "R6 handoff to r1", int'(grant), 2);
    rel(1, 7);
    chk(grant == '0, "R7 tail freed", int'(grant), 0);
    step('0, '0, '0, '0);
    acq(6, 5);
    chk(grant == 8'h40, "R7 reuse after free", int'(grant), 64);
    rel(6, 5);
    chk(grant == '0, "R7 free again", int'(grant), 0);

    // Same-cycle burst: order 0, 3, 6
    exp_q.push_back(0); exp_q.push_back(3); exp_q.push_back(6);
    step(8'b0100_1001, put(0, 2) | put(3, 4) | put(6, 6), '0, '0);
    chk(grant == 8'h01, "R4 lowest first", int'(grant), 1);
    repeat (3) step('0, '0, '0, '0);
    chk(grant == 8'h01, "R4 holder kept", int'(grant), 1);
    rel(0, 2);
    chk(grant == 8'h08, "R4 second r3", int'(grant), 8);
    rel(3, 4);
    chk(grant == 8'h40, "R4 third r6", int'(grant), 64);
    rel(6, 6);
    chk(grant == '0, "R7 burst drained", int'(grant), 0);

    // Release in the same cycle as the successor's tail swap
    acq(5, 3);
    chk(grant == 8'h20, "R2 r5 granted", int'(grant), 32);
    exp_q.push_back(7);
    step(8'h80, put(7, 0), 8'h20, put(5, 3));
    chk(grant == '0, "R8 wait edge1", int'(grant), 0);
    step('0, '0, '0, '0);
    chk(grant == '0, "R8 wait edge2", int'(grant), 0);
    step('0, '0, '0, '0);
    chk(grant == 8'h80, "R8 delayed handoff", int'(grant), 128);
    rel(7, 0);
    chk(grant == '0, "R7 idle", int'(grant), 0);

    // Release one cycle after the swap, link still in flight
    acq(1, 1);
    chk(grant == 8'h02, "R2 r1 granted", int'(grant), 2);
    acq(2, 2);
    rel(1, 1);
    chk(grant == '0, "R8 link pending", int'(grant), 0);
    step('0, '0, '0, '0);
    chk(grant == 8'h04, "R8 late handoff", int'(grant), 4);
    rel(2, 2);
    chk(grant == '0, "R7 final idle", int'(grant), 0);

    step('0, '0, '0, '0);
    chk(exp_q.size() == 0, "R5 all grants seen", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule